// File: doc/BRIEF.md
# Timer channel clock gating controller

This block sits in front of the counter of a single timer channel and decides, on every master clock cycle, whether the counter may advance. Eight count sources are available: five prescaled internal clocks that are already in the master clock domain, and three external inputs. The external inputs are retimed through a synchronizer before use. The chosen source can be inverted so that counting follows its falling edge instead of its rising edge. It can also be gated by one of the synchronized external inputs, so that edges pass only while that input is high.

On top of source selection there are two layers of control. An enable flag is set and cleared by command strobes, and it can also be cleared automatically by a capture load-B event or a waveform compare-C event. A run flag is set by any of four trigger pulses and can be cleared automatically by the same two events. The enable flag dominates: while it is clear the run flag stays clear, and triggers are ignored. The block produces a one-cycle count-enable pulse for each qualifying source edge while the channel is enabled and running, together with a registered clock-active status bit.

Top module: `tc_clk_gate`

## Requirements
- R1: `clk_sel` codes 0 to 4 select `int_clk[0]` to `int_clk[4]`, and codes 5, 6 and 7 select `xc_in[0]`, `xc_in[1]` and `xc_in[2]`. Each rising edge of the selected source yields exactly one `cnt_en` pulse. Sources that are not selected have no effect on `cnt_en`.
- R2: With `clk_inv` = 1, `cnt_en` pulses follow the falling edges of the selected source instead of its rising edges, with one pulse per falling edge.
- R3: `burst_sel` picks the gate: 0 means no gate, 1 means `xc_in[0]`, 2 means `xc_in[1]` and 3 means `xc_in[2]`. While the selected gate is low, no `cnt_en` pulse is produced, with or without inversion.
- R4: `cmd_en` sets the enable flag and `cmd_dis` clears it. When both are high in the same cycle, the flag ends up clear.
- R5: While the enable flag is clear, triggers and stop events have no effect, and `clk_active` stays 0 until `cmd_en` is given and a trigger follows.
- R6: Any of `trg_sw`, `trg_sync`, `trg_ext` or `trg_cmp` starts the clock when the flag is set. A trigger in the same cycle as `cmd_en` (with the flag previously clear) is ignored.
- R7: With `wave_mode` = 0, `opt_ldb_dis` = 1 and `ldb_evt` high, the enable flag is cleared. With `wave_mode` = 1, `opt_cpc_dis` = 1 and `cpc_evt` high, the flag is cleared. An event arriving in the other mode is ignored.
- R8: With `wave_mode` = 0, `opt_ldb_stop` = 1 and `ldb_evt` high, the clock is stopped. With `wave_mode` = 1, `opt_cpc_stop` = 1 and `cpc_evt` high, the clock is stopped. An event in the other mode is ignored, and a trigger in the same cycle overrides the stop.
- R9: `clk_active` is 1 exactly when the channel is enabled and running. It reflects the state left by the most recent clock edge.
- R10: While `rst` is high, the enable flag is cleared and the clock is stopped. `cnt_en` and `clk_active` read 0 after the reset edge.
- R11: `cnt_en` is never high in two consecutive cycles, and it pulses only while the clock is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst | input | 1 | synchronous active-high reset |
| int_clk | input | 5 | internal prescaled clock levels, master clock domain |
| xc_in | input | 3 | external clock inputs, asynchronous |
| clk_sel | input | 3 | count source select code |
| clk_inv | input | 1 | invert the selected source |
| burst_sel | input | 2 | gate select: none or one of the external inputs |
| wave_mode | input | 1 | 0 capture mode, 1 waveform mode |
| opt_ldb_stop | input | 1 | load-B event stops the clock in capture mode |
| opt_ldb_dis | input | 1 | load-B event disables the clock in capture mode |
| opt_cpc_stop | input | 1 | compare-C event stops the clock in waveform mode |
| opt_cpc_dis | input | 1 | compare-C event disables the clock in waveform mode |
| cmd_en | input | 1 | enable command strobe |
| cmd_dis | input | 1 | disable command strobe |
| trg_sw | input | 1 | software trigger pulse |
| trg_sync | input | 1 | synchro trigger pulse |
| trg_ext | input | 1 | external trigger pulse |
| trg_cmp | input | 1 | compare trigger pulse |
| ldb_evt | input | 1 | capture load-B event pulse |
| cpc_evt | input | 1 | compare-C event pulse |
| cnt_en | output | 1 | one-cycle count-enable pulse |
| clk_active | output | 1 | channel enabled and running |

## Verification
Three pairs of control functions can collide within one cycle. A trigger can coincide with an automatic stop event, an enable command can coincide with a disable command, and an enable command can coincide with a trigger. The bench raises each pair of strobes together on the same falling edge. It then reads `clk_active` after the next rising edge and issues a plain trigger one cycle later to show whether the enable flag survived. Source selection, inversion and burst gating are judged by counting `cnt_en` pulses across a fixed square-wave window on one source while the other sources are held still.

// File: rtl/tc_clk_gate_pkg.sv
package tc_clk_gate_pkg;

  typedef enum logic {
    MODE_CAPTURE = 1'b0,
    MODE_WAVE    = 1'b1
  } tc_mode_e;

  typedef struct packed {
    logic on_ldb_stop;
    logic on_ldb_dis;
    logic on_cpc_stop;
    logic on_cpc_dis;
  } tc_auto_t;

endpackage

// File: rtl/tc_sync.sv
module tc_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar si = 0; si < STAGES; si++) begin : g_stage
      if (si == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[si] <= '0;
          else     stg[si] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[si] <= '0;
          else     stg[si] <= stg[si-1];
        end
      end
    end
  endgenerate

  assign q_sync = stg[STAGES-1];

endmodule

// File: rtl/tc_clk_src.sv
module tc_clk_src #(
  parameter int NUM_INT = 5,
  parameter int NUM_EXT = 3,
  parameter int SEL_W   = 3,
  parameter int BURST_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_INT-1:0] int_lvl,
  input  logic [NUM_EXT-1:0] ext_lvl,
  input  logic [SEL_W-1:0]   sel,
  input  logic               inv,
  input  logic [BURST_W-1:0] burst,
  output logic               rise
);

  localparam int NUM_SRC    = NUM_INT + NUM_EXT;
  localparam int SRC_SLOTS  = 1 << SEL_W;
  localparam int GATE_SLOTS = 1 << BURST_W;

  logic [SRC_SLOTS-1:0]  slot;
  logic [GATE_SLOTS-1:0] gate;
  logic                  lvl;
  logic                  prev_q;

  generate
    for (genvar gi = 0; gi < SRC_SLOTS; gi++) begin : g_slot
      if (gi < NUM_INT) begin : g_int
        assign slot[gi] = int_lvl[gi];
      end else if (gi < NUM_SRC) begin : g_ext
        assign slot[gi] = ext_lvl[gi-NUM_INT];
      end else begin : g_none
        assign slot[gi] = 1'b0;
      end
    end
    for (genvar gj = 0; gj < GATE_SLOTS; gj++) begin : g_gate
      if (gj == 0) begin : g_open
        assign gate[gj] = 1'b1;
      end else if (gj <= NUM_EXT) begin : g_ext
        assign gate[gj] = ext_lvl[gj-1];
      end else begin : g_shut
        assign gate[gj] = 1'b0;
      end
    end
  endgenerate

  // level after inversion and burst gating
  assign lvl = (slot[sel] ^ inv) & gate[burst];

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;

  // R3
  gate_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!gate[burst]) |-> !rise);

endmodule

// File: rtl/tc_clk_ctrl.sv
module tc_clk_ctrl
  import tc_clk_gate_pkg::*;
#(
  parameter int NUM_TRIG = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_en,
  input  logic                cmd_dis,
  input  logic [NUM_TRIG-1:0] trig,
  input  logic                wave_mode,
  input  tc_auto_t            auto_cfg,
  input  logic                ldb_evt,
  input  logic                cpc_evt,
  output logic                en_q,
  output logic                run_q,
  output logic                active_q
);

  logic is_wave, is_cap, any_trig;
  logic auto_dis, auto_stop, dis_now;
  logic en_d, run_d;

  assign is_wave  = (wave_mode == MODE_WAVE);
  assign is_cap   = (wave_mode == MODE_CAPTURE);
  assign any_trig = |trig;

  assign auto_dis  = (is_cap  & auto_cfg.on_ldb_dis  & ldb_evt) |
                     (is_wave & auto_cfg.on_cpc_dis  & cpc_evt);
  assign auto_stop = (is_cap  & auto_cfg.on_ldb_stop & ldb_evt) |
                     (is_wave & auto_cfg.on_cpc_stop & cpc_evt);
  assign dis_now   = cmd_dis | auto_dis;

  always_comb begin
    en_d  = en_q;
    run_d = run_q;
    if (dis_now) begin
      en_d  = 1'b0;
      run_d = 1'b0;
    end else begin
      if (cmd_en) en_d = 1'b1;
      if (en_q && any_trig)       run_d = 1'b1;
      else if (en_q && auto_stop) run_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      run_q    <= 1'b0;
      active_q <= 1'b0;
    end else begin
      en_q     <= en_d;
      run_q    <= run_d;
      active_q <= en_d & run_d;
    end
  end

  // R4
  dis_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_en && cmd_dis) |=> (!en_q && !active_q));

  // R4
  en_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_en && !dis_now) |=> en_q);

  // R5
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_q) |=> !active_q);

  // R6
  trig_start_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q && any_trig && !dis_now) |=> active_q);

  // R7
  ldb_dis_chk: assert property (@(posedge clk) disable iff (rst)
    (is_cap && auto_cfg.on_ldb_dis && ldb_evt) |=> !en_q);

  // R7
  cpc_dis_chk: assert property (@(posedge clk) disable iff (rst)
    (is_wave && auto_cfg.on_cpc_dis && cpc_evt) |=> !en_q);

  // R8
  auto_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (auto_stop && !any_trig) |=> !active_q);

  // R9
  status_chk: assert property (@(posedge clk) disable iff (rst)
    active_q |-> (en_q && run_q));

endmodule

// File: rtl/tc_clk_gate.sv
module tc_clk_gate
  import tc_clk_gate_pkg::*;
#(
  parameter int NUM_INT     = 5,
  parameter int NUM_EXT     = 3,
  parameter int SYNC_STAGES = 2,
  parameter int NUM_TRIG    = 4,
  localparam int SEL_W      = $clog2(NUM_INT + NUM_EXT),
  localparam int BURST_W    = $clog2(NUM_EXT + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_INT-1:0] int_clk,
  input  logic [NUM_EXT-1:0] xc_in,
  input  logic [SEL_W-1:0]   clk_sel,
  input  logic               clk_inv,
  input  logic [BURST_W-1:0] burst_sel,
  input  logic               wave_mode,
  input  logic               opt_ldb_stop,
  input  logic               opt_ldb_dis,
  input  logic               opt_cpc_stop,
  input  logic               opt_cpc_dis,
  input  logic               cmd_en,
  input  logic               cmd_dis,
  input  logic               trg_sw,
  input  logic               trg_sync,
  input  logic               trg_ext,
  input  logic               trg_cmp,
  input  logic               ldb_evt,
  input  logic               cpc_evt,
  output logic               cnt_en,
  output logic               clk_active
);

  logic [NUM_EXT-1:0]  xc_s;
  logic                src_rise;
  logic                en_q, run_q, active_q;
  logic                cnt_en_q;
  logic [NUM_TRIG-1:0] trig_vec;
  tc_auto_t            auto_cfg;

  assign trig_vec = NUM_TRIG'({trg_cmp, trg_ext, trg_sync, trg_sw});
  assign auto_cfg = '{on_ldb_stop: opt_ldb_stop, on_ldb_dis: opt_ldb_dis,
                      on_cpc_stop: opt_cpc_stop, on_cpc_dis: opt_cpc_dis};

  tc_sync #(.WIDTH(NUM_EXT), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (xc_in),
    .q_sync  (xc_s)
  );

  tc_clk_src #(
    .NUM_INT (NUM_INT),
    .NUM_EXT (NUM_EXT),
    .SEL_W   (SEL_W),
    .BURST_W (BURST_W)
  ) u_src (
    .clk     (clk),
    .rst     (rst),
    .int_lvl (int_clk),
    .ext_lvl (xc_s),
    .sel     (clk_sel),
    .inv     (clk_inv),
    .burst   (burst_sel),
    .rise    (src_rise)
  );

  tc_clk_ctrl #(.NUM_TRIG(NUM_TRIG)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cmd_en    (cmd_en),
    .cmd_dis   (cmd_dis),
    .trig      (trig_vec),
    .wave_mode (wave_mode),
    .auto_cfg  (auto_cfg),
    .ldb_evt   (ldb_evt),
    .cpc_evt   (cpc_evt),
    .en_q      (en_q),
    .run_q     (run_q),
    .active_q  (active_q)
  );

  always_ff @(posedge clk) begin
    if (rst) cnt_en_q <= 1'b0;
    else     cnt_en_q <= src_rise & run_q & en_q;
  end

  assign cnt_en     = cnt_en_q;
  assign clk_active = active_q;

  // R10
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!cnt_en && !clk_active));

  // R11
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_en |=> !cnt_en);

  // R11
  pulse_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_en |-> $past(run_q));

endmodule

// File: tb/tc_clk_gate_tb.sv
module tc_clk_gate_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] int_clk = '0;
  logic [2:0] xc_in = '0;
  logic [2:0] clk_sel = '0;
  logic       clk_inv = 1'b0;
  logic [1:0] burst_sel = '0;
  logic       wave_mode = 1'b0;
  logic       opt_ldb_stop = 1'b0, opt_ldb_dis = 1'b0;
  logic       opt_cpc_stop = 1'b0, opt_cpc_dis = 1'b0;
  logic       cmd_en = 1'b0, cmd_dis = 1'b0;
  logic       trg_sw = 1'b0, trg_sync = 1'b0, trg_ext = 1'b0, trg_cmp = 1'b0;
  logic       ldb_evt = 1'b0, cpc_evt = 1'b0;
  logic       cnt_en, clk_active;

  int  checks = 0;
  int  errors = 0;
  int  double_hits = 0;
  bit  done = 1'b0;
  logic prev_ce = 1'b0;

  always #4 clk = ~clk;

  tc_clk_gate u_dut (
    .clk(clk), .rst(rst), .int_clk(int_clk), .xc_in(xc_in),
    .clk_sel(clk_sel), .clk_inv(clk_inv), .burst_sel(burst_sel),
    .wave_mode(wave_mode), .opt_ldb_stop(opt_ldb_stop), .opt_ldb_dis(opt_ldb_dis),
    .opt_cpc_stop(opt_cpc_stop), .opt_cpc_dis(opt_cpc_dis),
    .cmd_en(cmd_en), .cmd_dis(cmd_dis), .trg_sw(trg_sw), .trg_sync(trg_sync),
    .trg_ext(trg_ext), .trg_cmp(trg_cmp), .ldb_evt(ldb_evt), .cpc_evt(cpc_evt),
    .cnt_en(cnt_en), .clk_active(clk_active)
  );

  // stimulus vectors: source toggled by mask (bits 0-4 int, 5-7 xc), static xc levels, expected pulses
  typedef struct packed {
    logic [1:0] req;
    logic [2:0] sel;
    logic       inv;
    logic [1:0] burst;
    logic [7:0] tog;
    logic [2:0] xcs;
    logic [4:0] exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 3'd0, 1'b0, 2'd0, 8'h01, 3'b000, 5'd8},
    '{2'd1, 3'd4, 1'b0, 2'd0, 8'h10, 3'b000, 5'd8},
    '{2'd1, 3'd2, 1'b0, 2'd0, 8'h01, 3'b000, 5'd0},
    '{2'd2, 3'd0, 1'b1, 2'd0, 8'h01, 3'b000, 5'd8},
    '{2'd1, 3'd5, 1'b0, 2'd0, 8'h20, 3'b000, 5'd8},
    '{2'd1, 3'd7, 1'b0, 2'd0, 8'h80, 3'b000, 5'd8},
    '{2'd1, 3'd6, 1'b0, 2'd0, 8'h80, 3'b000, 5'd0},
    '{2'd2, 3'd6, 1'b1, 2'd0, 8'h40, 3'b000, 5'd8},
    '{2'd3, 3'd0, 1'b0, 2'd1, 8'h01, 3'b001, 5'd8},
    '{2'd3, 3'd0, 1'b0, 2'd1, 8'h01, 3'b000, 5'd0},
    '{2'd3, 3'd3, 1'b0, 2'd2, 8'h08, 3'b010, 5'd8},
    '{2'd3, 3'd3, 1'b0, 2'd3, 8'h08, 3'b011, 5'd0},
    '{2'd3, 3'd1, 1'b0, 2'd3, 8'h02, 3'b100, 5'd8},
    '{2'd3, 3'd1, 1'b1, 2'd1, 8'h02, 3'b000, 5'd0}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // R11 monitor: consecutive pulses
  always @(negedge clk) begin
    if (!rst && cnt_en && prev_ce) double_hits++;
    prev_ce <= cnt_en;
  end

  task automatic toggle_count(input logic [7:0] tog, input logic [2:0] xcs, input int n, output int cnt);
    cnt = 0;
    for (int p = 0; p < n; p++) begin
      logic lv;
      lv = p[2];
      int_clk = tog[4:0] & {5{lv}};
      xc_in   = (tog[7:5] & {3{lv}}) | (~tog[7:5] & xcs);
      tick();
      if (cnt_en) cnt++;
    end
    int_clk = '0;
    xc_in   = xcs;
    for (int d = 0; d < 6; d++) begin
      tick();
      if (cnt_en) cnt++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R-all actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int cnt;
    string tag;
    @(negedge clk);
    repeat (3) tick();
    // R10
    check(cnt_en == 1'b0, "R10 cnt_en in reset", cnt_en, 0);
    check(clk_active == 1'b0, "R10 clk_active in reset", clk_active, 0);
    rst = 1'b0;
    tick();
    check(clk_active == 1'b0, "R10 idle after reset", clk_active, 0);

    // R5: trigger while flag clear
    trg_sw = 1'b1; tick(); trg_sw = 1'b0;
    check(clk_active == 1'b0, "R5 trigger ignored while disabled", clk_active, 0);

    // R6: trigger together with enable is ignored
    cmd_en = 1'b1; trg_sw = 1'b1; tick(); cmd_en = 1'b0; trg_sw = 1'b0;
    check(clk_active == 1'b0, "R6 trigger with enable ignored", clk_active, 0);
    trg_sw = 1'b1; tick(); trg_sw = 1'b0;
    check(clk_active == 1'b1, "R6 software trigger starts", clk_active, 1);
    // R9
    check(clk_active == 1'b1, "R9 status when enabled and running", clk_active, 1);

    // source selection, inversion, burst table (R1 R2 R3)
    for (int v = 0; v < NV; v++) begin
      clk_sel = VECS[v].sel;
      clk_inv = VECS[v].inv;
      burst_sel = VECS[v].burst;
      int_clk = '0;
      xc_in = VECS[v].xcs;
      repeat (6) tick();
      toggle_count(VECS[v].tog, VECS[v].xcs, 64, cnt);
      case (VECS[v].req)
        2'd1:    tag = $sformatf("R1 vector %0d", v);
        2'd2:    tag = $sformatf("R2 vector %0d", v);
        default: tag = $sformatf("R3 vector %0d", v);
      endcase
      check(cnt == int'(VECS[v].exp), tag, cnt, int'(VECS[v].exp));
    end
    clk_sel = 3'd0; clk_inv = 1'b0; burst_sel = 2'd0;
    int_clk = '0; xc_in = '0;
    repeat (6) tick();

    // R8: load-B stop in capture mode
    opt_ldb_stop = 1'b1; opt_cpc_stop = 1'b1;
    ldb_evt = 1'b1; tick(); ldb_evt = 1'b0;
    check(clk_active == 1'b0, "R8 load-B stop in capture", clk_active, 0);
    // R11: no pulses while stopped
    toggle_count(8'h01, 3'b000, 32, cnt);
    check(cnt == 0, "R11 no pulses while stopped", cnt, 0);
    trg_sync = 1'b1; tick(); trg_sync = 1'b0;
    check(clk_active == 1'b1, "R6 synchro trigger restarts", clk_active, 1);
    cpc_evt = 1'b1; tick(); cpc_evt = 1'b0;
    check(clk_active == 1'b1, "R8 compare-C ignored in capture", clk_active, 1);
    wave_mode = 1'b1;
    cpc_evt = 1'b1; tick(); cpc_evt = 1'b0;
    check(clk_active == 1'b0, "R8 compare-C stop in waveform", clk_active, 0);
    trg_ext = 1'b1; tick(); trg_ext = 1'b0;
    check(clk_active == 1'b1, "R6 external trigger restarts", clk_active, 1);
    cpc_evt = 1'b1; trg_cmp = 1'b1; tick(); cpc_evt = 1'b0; trg_cmp = 1'b0;
    check(clk_active == 1'b1, "R8 trigger overrides stop", clk_active, 1);
    ldb_evt = 1'b1; tick(); ldb_evt = 1'b0;
    check(clk_active == 1'b1, "R8 load-B ignored in waveform", clk_active, 1);
    opt_ldb_stop = 1'b0; opt_cpc_stop = 1'b0;

    // R7: compare-C disable in waveform mode
    opt_cpc_dis = 1'b1; opt_ldb_dis = 1'b1;
    cpc_evt = 1'b1; tick(); cpc_evt = 1'b0;
    check(clk_active == 1'b0, "R7 compare-C disables", clk_active, 0);
    trg_cmp = 1'b1; tick(); trg_cmp = 1'b0;
    check(clk_active == 1'b0, "R7 trigger ignored after auto-disable", clk_active, 0);
    cmd_en = 1'b1; tick(); cmd_en = 1'b0;
    trg_sw = 1'b1; tick(); trg_sw = 1'b0;
    check(clk_active == 1'b1, "R4 enable command re-arms", clk_active, 1);
    wave_mode = 1'b0;
    cpc_evt = 1'b1; tick(); cpc_evt = 1'b0;
    check(clk_active == 1'b1, "R7 compare-C ignored in capture", clk_active, 1);
    ldb_evt = 1'b1; tick(); ldb_evt = 1'b0;
    check(clk_active == 1'b0, "R7 load-B disables in capture", clk_active, 0);
    trg_sw = 1'b1; tick(); trg_sw = 1'b0;
    check(clk_active == 1'b0, "R7 flag stays clear", clk_active, 0);
    opt_cpc_dis = 1'b0; opt_ldb_dis = 1'b0;

    // R4: enable and disable together
    cmd_en = 1'b1; cmd_dis = 1'b1; tick(); cmd_en = 1'b0; cmd_dis = 1'b0;
    trg_sw = 1'b1; tick(); trg_sw = 1'b0;
    check(clk_active == 1'b0, "R4 disable wins over enable", clk_active, 0);
    cmd_en = 1'b1; tick(); cmd_en = 1'b0;
    trg_sw = 1'b1; tick(); trg_sw = 1'b0;
    check(clk_active == 1'b1, "R9 active after enable and trigger", clk_active, 1);
    cmd_dis = 1'b1; tick(); cmd_dis = 1'b0;
    check(clk_active == 1'b0, "R9 status drops on disable", clk_active, 0);
    trg_ext = 1'b1; tick(); trg_ext = 1'b0;
    check(clk_active == 1'b0, "R5 trigger ignored after disable", clk_active, 0);

    // R11
    check(double_hits == 0, "R11 consecutive pulses", double_hits, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule